// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Output

This block is a free-running timer/counter with one compare channel and a waveform generator that drives a single output pin. A timer tick input advances the counter. A two-bit mode input selects one of four counting sequences: a plain wrapping count, a count that restarts when it equals the compare value, a single-slope PWM and a dual-slope (up then down) PWM. A two-bit pin-action input then decides how compare matches and the counter's extreme values move the output pin. The counter width is a parameter and defaults to 8 bits.

Software loads the counter and the compare value through write strobes, reads back the compare buffer, and can force a compare action onto the pin in the non-PWM modes. The block has two flags: overflow and compare match. Each flag drives an interrupt request, gated by its own enable and a global enable. An interrupt acknowledge clears the matching flag, and so does a write-one-to-clear strobe. In the PWM modes the compare value is double-buffered. A written value waits in a buffer and reaches the comparator only when the counter is at its maximum. This keeps every pulse whole and symmetric.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, the compare buffer, the active compare value, both flags, both interrupt requests and the pin are all 0, and the count direction is up.
- R2: In mode 00 (wrapping count), each tick with no counter write adds one. A tick at the maximum value (all ones) wraps the counter to 0 and sets the overflow flag.
- R3: In mode 10 (clear on compare), a tick while the counter equals the active compare value loads 0. Otherwise the counter counts as in R2, and a tick at the maximum value wraps the counter and sets the overflow flag.
- R4: In mode 11 (single-slope PWM), the counter and the overflow flag behave as in R2. With pin action 10, a tick at the maximum value sets the pin, and a tick on a compare match clears it. If both happen on the same tick, the maximum-value action wins. Pin action 11 drives the opposite levels. Pin actions 00 and 01 leave the pin unchanged.
- R5: In mode 01 (dual-slope PWM), the counter steps up to the maximum value and then down to 0, and it turns back at each end. A tick at 0 while the direction is down sets the overflow flag. On a compare-match tick with pin action 10, the pin clears if that tick steps up and sets if it steps down. Pin action 11 drives the opposite levels. Pin actions 00 and 01 have no effect.
- R6: A tick taken while the counter equals the active compare value sets the compare flag. The flag therefore appears one tick after equality is reached.
- R7: The compare read port always shows the buffer. In modes 01 and 11, a compare write changes only the buffer, and the active value takes the buffer on a tick at the maximum value. In modes 00 and 10, a compare write loads both the buffer and the active value at once.
- R8: A counter write loads the written value and takes priority over the tick in the same cycle. That tick then changes neither the direction, the flags, the pin nor the active compare value.
- R9: An acknowledge or a write-one-to-clear strobe clears its flag. If a set and a clear fall in the same cycle, the set wins.
- R10: The compare request equals compare flag AND compare enable AND global enable. The overflow request equals overflow flag AND overflow enable AND global enable.
- R11: In modes 00 and 10, a force strobe applies the pin action at the next edge without a tick and without setting a flag: 01 toggles, 10 clears, 11 sets, 00 does nothing. The force replaces any tick action in that cycle. In the PWM modes the force strobe is ignored.
- R12: In modes 00 and 10, a compare-match tick toggles the pin with pin action 01, clears it with 10 and sets it with 11. With pin action 00 the pin is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick (count enable) |
| mode | input | 2 | Counting sequence select |
| com | input | 2 | Pin action select |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| ocr_we | input | 1 | Compare write strobe |
| ocr_wdata | input | W | Compare write value |
| foc | input | 1 | Force compare strobe |
| ocie | input | 1 | Compare interrupt enable |
| toie | input | 1 | Overflow interrupt enable |
| gie | input | 1 | Global interrupt enable |
| ocf_clr | input | 1 | Write-one-to-clear for compare flag |
| tov_clr | input | 1 | Write-one-to-clear for overflow flag |
| ocf_ack | input | 1 | Compare interrupt acknowledge |
| tov_ack | input | 1 | Overflow interrupt acknowledge |
| cnt_o | output | W | Counter value |
| ocr_rd | output | W | Compare buffer read-back |
| oc_pin | output | 1 | Waveform output pin |
| ocf | output | 1 | Compare match flag |
| tov | output | 1 | Overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with W = 4, so the maximum value is 15. A full wrap takes 16 ticks and a dual-slope period takes 30 ticks. Every mode and pin action can therefore be swept through many complete periods, with compare values of 0, 15 and points in between. The short periods also make coincidences frequent during a long randomized stretch: a buffer transfer on the same tick as a match, a flag set in the same cycle as its clear, and a counter write at a turning point.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [1:0]   com,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         ocr_we,
  input  logic [W-1:0] ocr_wdata,
  input  logic         foc,
  input  logic         ocie,
  input  logic         toie,
  input  logic         gie,
  input  logic         ocf_clr,
  input  logic         tov_clr,
  input  logic         ocf_ack,
  input  logic         tov_ack,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ocr_rd,
  output logic         oc_pin,
  output logic         ocf,
  output logic         tov,
  output logic         cmp_irq,
  output logic         ovf_irq
);
  localparam logic [W-1:0] TOP_V = {W{1'b1}};
  localparam logic [1:0] M_WRAP = 2'b00, M_DUAL = 2'b01, M_CLR = 2'b10, M_FAST = 2'b11;

  logic [W-1:0] cnt_q, buf_q, act_q, cnt_d;
  logic up_q, up_d, oc_q, oc_d, ocf_q, tov_q, ovf_hit;

  wire step   = tick & ~cnt_we;
  wire match  = (cnt_q == act_q);
  wire at_top = (cnt_q == TOP_V);
  wire at_bot = (cnt_q == '0);
  wire pwm    = mode[0];
  wire rising = at_bot | (up_q & ~at_top);

  function automatic logic pin_act(input logic [1:0] c, input logic cur);
    case (c)
      2'b01:   pin_act = ~cur;
      2'b10:   pin_act = 1'b0;
      2'b11:   pin_act = 1'b1;
      default: pin_act = cur;
    endcase
  endfunction

  always_comb begin
    cnt_d   = cnt_q;
    up_d    = up_q;
    ovf_hit = 1'b0;
    if (cnt_we) cnt_d = cnt_wdata;
    else if (tick) begin
      case (mode)
        M_DUAL: begin
          cnt_d   = rising ? cnt_q + 1'b1 : cnt_q - 1'b1;
          up_d    = rising;
          ovf_hit = at_bot & ~up_q;
        end
        M_CLR: begin
          cnt_d   = (match | at_top) ? '0 : cnt_q + 1'b1;
          ovf_hit = at_top;
        end
        default: begin
          cnt_d   = cnt_q + 1'b1;
          ovf_hit = at_top;
        end
      endcase
    end
  end

  always_comb begin
    oc_d = oc_q;
    if (foc & ~pwm) oc_d = pin_act(com, oc_q);
    else if (step) begin
      case (mode)
        M_FAST: begin
          if (com[1] & at_top)     oc_d = ~com[0];
          else if (com[1] & match) oc_d = com[0];
        end
        M_DUAL: if (com[1] & match) oc_d = rising ? com[0] : ~com[0];
        default: if (match) oc_d = pin_act(com, oc_q);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
      act_q <= '0;
      up_q  <= 1'b1;
      oc_q  <= 1'b0;
      ocf_q <= 1'b0;
      tov_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      oc_q  <= oc_d;
      if (ocr_we) buf_q <= ocr_wdata;
      if (ocr_we & ~pwm)              act_q <= ocr_wdata;
      else if (pwm & step & at_top)   act_q <= buf_q;
      ocf_q <= (step & match) | (ocf_q & ~(ocf_ack | ocf_clr));
      tov_q <= ovf_hit | (tov_q & ~(tov_ack | tov_clr));
    end
  end

  assign cnt_o   = cnt_q;
  assign ocr_rd  = buf_q;
  assign oc_pin  = oc_q;
  assign ocf     = ocf_q;
  assign tov     = tov_q;
  assign cmp_irq = ocf_q & ocie & gie;
  assign ovf_irq = tov_q & toie & gie;

  // R8
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_o == $past(cnt_wdata)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt_o));

  // R6
  ocf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocf) |-> $past(step && match));

  // R2
  tov_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tov) |-> $past(tick && !cnt_we));

  // R7
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !(step && at_top)) |=> $stable(act_q));

  // R11
  pwm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && foc && !tick) |=> $stable(oc_pin));
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  localparam int W  = 4;
  localparam int MX = (1 << W) - 1;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] mode = 0, com = 0;
  logic cnt_we = 0, ocr_we = 0, foc = 0;
  logic [W-1:0] cnt_wdata = 0, ocr_wdata = 0;
  logic ocie = 0, toie = 0, gie = 0;
  logic ocf_clr = 0, tov_clr = 0, ocf_ack = 0, tov_ack = 0;
  logic [W-1:0] cnt_o, ocr_rd;
  logic oc_pin, ocf, tov, cmp_irq, ovf_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  cmp_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .com(com),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ocr_we(ocr_we), .ocr_wdata(ocr_wdata),
    .foc(foc), .ocie(ocie), .toie(toie), .gie(gie),
    .ocf_clr(ocf_clr), .tov_clr(tov_clr), .ocf_ack(ocf_ack), .tov_ack(tov_ack),
    .cnt_o(cnt_o), .ocr_rd(ocr_rd), .oc_pin(oc_pin), .ocf(ocf), .tov(tov),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq));

  always #5 clk = ~clk;

  int m_cnt, m_buf, m_act;
  bit m_up, m_oc, m_ocf, m_tov;
  bit p_we, p_foc, p_ocfclr, p_tovclr;

  always @(posedge clk) begin
    bit hit, up_step, fire, pwm_m;
    int nxt;
    p_we = cnt_we; p_foc = foc;
    p_ocfclr = ocf_clr | ocf_ack; p_tovclr = tov_clr | tov_ack;
    if (!rst_n) begin
      m_cnt = 0; m_buf = 0; m_act = 0; m_up = 1; m_oc = 0; m_ocf = 0; m_tov = 0;
    end else begin
      hit = (m_cnt == m_act);
      pwm_m = (mode == 1 || mode == 3);
      fire = tick && !cnt_we;
      up_step = (m_cnt == 0) || (m_up && m_cnt != MX);
      if (m_ocf && p_ocfclr) m_ocf = 0;
      if (m_tov && p_tovclr) m_tov = 0;
      if (foc && !pwm_m) begin
        if (com == 1) m_oc = !m_oc; else if (com == 2) m_oc = 0; else if (com == 3) m_oc = 1;
      end else if (fire) begin
        if (mode == 3) begin
          if (com >= 2) begin
            if (m_cnt == MX) m_oc = (com == 2); else if (hit) m_oc = (com == 3);
          end
        end else if (mode == 1) begin
          if (com >= 2 && hit) m_oc = up_step ? (com == 3) : (com == 2);
        end else if (hit) begin
          if (com == 1) m_oc = !m_oc; else if (com == 2) m_oc = 0; else if (com == 3) m_oc = 1;
        end
      end
      nxt = m_cnt;
      if (cnt_we) nxt = int'(cnt_wdata);
      else if (tick) begin
        if (mode == 1) begin
          if (m_cnt == 0 && !m_up) m_tov = 1;
          nxt = up_step ? m_cnt + 1 : m_cnt - 1;
          m_up = up_step;
        end else begin
          if (m_cnt == MX) m_tov = 1;
          nxt = (m_cnt + 1) % (MX + 1);
          if (mode == 2 && hit) nxt = 0;
        end
      end
      if (fire && hit) m_ocf = 1;
      if (ocr_we && !pwm_m) m_act = int'(ocr_wdata);
      else if (pwm_m && fire && m_cnt == MX) m_act = m_buf;
      if (ocr_we) m_buf = int'(ocr_wdata);
      m_cnt = nxt;
    end
  end

  task automatic chk(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string tc;
    tc = p_we ? "R8" : (mode == 0 ? "R2" : mode == 2 ? "R3" : mode == 3 ? "R4" : "R5");
    chk(int'(cnt_o), m_cnt, tc, "count");
    chk(int'(tov), int'(m_tov), p_tovclr ? "R9" : tc, "overflow flag");
    chk(int'(ocf), int'(m_ocf), p_ocfclr ? "R9" : (mode[0] ? "R7" : "R6"), "compare flag");
    chk(int'(oc_pin), int'(m_oc), p_foc ? "R11" : (mode[0] ? tc : "R12"), "pin");
    chk(int'(ocr_rd), m_buf, "R7", "compare read");
    chk(int'(cmp_irq), int'(m_ocf & ocie & gie), "R10", "compare request");
    chk(int'(ovf_irq), int'(m_tov & toie & gie), "R10", "overflow request");
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk); #2;
      compare_all();
    end
  endtask

  task automatic wr_ocr(int v);
    ocr_wdata = W'(v); ocr_we = 1; cyc(1); ocr_we = 0;
  endtask

  task automatic wr_cnt(int v);
    cnt_wdata = W'(v); cnt_we = 1; cyc(1); cnt_we = 0;
  endtask

  task automatic pulse_foc();
    foc = 1; cyc(1); foc = 0;
  endtask

  initial begin
    #1900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    chk(int'(cnt_o), 0, "R1", "reset count");
    chk(int'(oc_pin), 0, "R1", "reset pin");
    chk(int'(ocf) + int'(tov), 0, "R1", "reset flags");
    chk(int'(ocr_rd), 0, "R1", "reset compare");
    cyc(2);
    gie = 1; ocie = 1; toie = 1;

    mode = 0; com = 1; wr_ocr(5); tick = 1; cyc(40);
    for (int i = 0; i < 30; i++) begin tick = i[0]; cyc(1); end
    tick = 1; ocf_clr = 1; cyc(1); ocf_clr = 0; tov_ack = 1; cyc(1); tov_ack = 0;
    com = 2; pulse_foc(); com = 1; pulse_foc(); com = 3; pulse_foc(); cyc(20);

    mode = 2; com = 2; wr_ocr(6); cyc(30);
    com = 3; cyc(10); com = 1; cyc(20); wr_ocr(15); cyc(40); wr_ocr(0); cyc(10);
    wr_cnt(9); cyc(5); wr_cnt(12); cyc(10);

    mode = 3; com = 2; wr_ocr(9); cyc(40);
    wr_ocr(15); cyc(40); wr_ocr(0); cyc(40);
    com = 3; wr_ocr(7); cyc(40); pulse_foc(); cyc(5);
    com = 1; cyc(20); gie = 0; cyc(10); gie = 1;

    mode = 1; com = 2; wr_ocr(4); cyc(80);
    com = 3; wr_ocr(15); cyc(40); wr_ocr(0); cyc(70);
    com = 2; wr_ocr(10); cyc(20); wr_cnt(3); cyc(30); pulse_foc(); cyc(10);
    ocf_ack = 1; tov_clr = 1; cyc(3); ocf_ack = 0; tov_clr = 0; cyc(10);

    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 150) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 60) == 0) com = 2'($urandom_range(0, 3));
      ocr_we = ($urandom_range(0, 25) == 0); ocr_wdata = W'($urandom_range(0, MX));
      cnt_we = ($urandom_range(0, 40) == 0); cnt_wdata = W'($urandom_range(0, MX));
      foc = ($urandom_range(0, 20) == 0);
      ocf_clr = ($urandom_range(0, 12) == 0); ocf_ack = ($urandom_range(0, 12) == 0);
      tov_clr = ($urandom_range(0, 12) == 0); tov_ack = ($urandom_range(0, 12) == 0);
      ocie = ($urandom_range(0, 7) != 0); toie = ($urandom_range(0, 7) != 0);
      gie = ($urandom_range(0, 7) != 0);
      cyc(1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule